// File: doc/BRIEF.md
# Flash Read-to-Memory Engine

The block runs one read from a serial flash device over a single-lane SPI link and stores the returned data in a memory buffer, one 32-bit word at a time. Software first sets up a small register file: the command opcode and a 24-bit flash address, the dummy-clock counts, the buffer base and the read length. It then sets a start bit. The engine lowers chip select and shifts out the opcode followed by the address. It then runs the programmed number of dummy clocks, receives the data bits and packs every four bytes into a word. Each word goes out on a plain memory-write port as a single-cycle strobe.

When the last word has been written, chip select goes high and a sticky completion flag is set in a 16-bit status register. Software clears the flag by writing a one to it. An interrupt line follows the status bits through per-bit enables held in the upper half of the mask register. A self-clearing control bit resets the receive logic at any time. Used during a read, it abandons the read.

Top module: `flash_dma_reader`

## Requirements
- R1: After reset, every register reads zero, `spiCsN` is high, `spiSclk` is low, and `irq` and `memWrEn` are low.
- R2: A start sends a frame with `spiCsN` low. The opcode (index 0, bits [7:0]) goes first, then the flash address (index 0, bits [31:8]), as 32 bits, most significant bit first, each valid at the rising `spiSclk` edge. Every SPI bit lasts 2*HALF_DIV clocks, `spiCsN` stays low for exactly that many clocks per bit of the frame, and `spiSclk` is low whenever `spiCsN` is high.
- R3: The fast-read count at index 2, bits [4:0], inserts that many SPI clocks with `spiMosi` low between the address and the data. A count of zero inserts none. The dual count [12:8], the quad count [20:16] and the preamble count [27:24] do not change the frame.
- R4: Data bytes arrive most significant bit first and are packed little-endian, so the first byte lands in bits [7:0]. Word i is written to {base[31:12], 12'h000} + 4*i, where base is the buffer register at index 3.
- R5: The length register (index 1, bits [15:0]) holds the word count minus one. A read of length value L writes exactly L+1 words and clocks 32 + dummy + 32*(L+1) SPI bits.
- R6: Status bit 3 (index 5) is set once the last word is written and chip select is high. It stays set until a write with bit 3 set. Writing zeros leaves it set.
- R7: Writing bit 3 of the start register (index 4) begins a read when the engine is idle. The bit reads back zero once the read is accepted. A start written during a read is ignored and does not cause a later read.
- R8: `irq` is high while any status bit k is set and mask bit 16+k (index 6) is set. The completion interrupt is enabled by mask bit 19.
- R9: Writing bit 5 of the control register (index 7) resets the receive logic. During a read this raises chip select within three clocks, stops further word writes and leaves the completion flag clear. The bit reads back zero, and the next read writes from word 0 again.
- R10: The registers read back only their implemented bits: index 0 all 32 bits, index 1 bits [15:0], index 2 mask 32'h0F1F1F1F, index 3 mask 32'hFFFFF03F, index 6 all bits, index 7 bit 3 only (the buffer-unit select).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | SPI clock, idle low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| memWrEn | output | 1 | One-cycle word write strobe |
| memWrAddr | output | 32 | Byte address of the written word |
| memWrData | output | 32 | Written word |
| irq | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
The bench builds the block with HALF_DIV = 2 and the default 16-bit length field. This makes each SPI bit four clocks long, so frames of up to four words with 31 dummy clocks stay short. The three reads use dummy counts 0, 8 and 31 to reach both ends of the dummy field. With nonzero dual and quad fields, they also show that those fields do not change a single-lane frame. The short bit time also lets the bench write a second start and a receive reset partway through a frame, at a known word.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

  localparam logic [2:0] REG_CMD     = 3'd0;
  localparam logic [2:0] REG_LEN     = 3'd1;
  localparam logic [2:0] REG_DUMMY   = 3'd2;
  localparam logic [2:0] REG_BUF     = 3'd3;
  localparam logic [2:0] REG_START   = 3'd4;
  localparam logic [2:0] REG_STATUS  = 3'd5;
  localparam logic [2:0] REG_MASK    = 3'd6;
  localparam logic [2:0] REG_CONTROL = 3'd7;

  localparam logic [31:0] DUMMY_KEEP = 32'h0F1F_1F1F;
  localparam logic [31:0] BUF_KEEP   = 32'hFFFF_F03F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DUMMY,
    ST_DATA
  } fdrState_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftTx;
    logic sampleRx;
    logic clearRx;
  } fdrStrobe_t;

endpackage

// File: rtl/fdr_regs.sv
module fdr_regs
  import fdr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic             busy,
  input  logic             accept,
  input  logic             doneSet,
  output logic             startPend,
  output logic             rxReset,
  output logic [31:0]      cmdWord,
  output logic [LEN_W-1:0] lenWords,
  output logic [4:0]       dummyFast,
  output logic [19:0]      bufBase,
  output logic             irq
);

  logic [31:0] dummyReg;
  logic [31:0] bufReg;
  logic [31:0] maskReg;
  logic        doneBit;
  logic        unitBit;
  logic [15:0] statusVec;

  assign statusVec = {12'h000, doneBit, 3'b000};
  assign irq       = |(statusVec & maskReg[31:16]);
  assign dummyFast = dummyReg[4:0];
  assign bufBase   = bufReg[31:12];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord   <= '0;
      lenWords  <= '0;
      dummyReg  <= '0;
      bufReg    <= '0;
      maskReg   <= '0;
      doneBit   <= 1'b0;
      unitBit   <= 1'b0;
      startPend <= 1'b0;
      rxReset   <= 1'b0;
    end else begin
      rxReset <= wrEn && (addr == REG_CONTROL) && wrData[5];
      if (accept || rxReset) startPend <= 1'b0;
      if (wrEn) begin
        case (addr)
          REG_CMD:     cmdWord  <= wrData;
          REG_LEN:     lenWords <= wrData[LEN_W-1:0];
          REG_DUMMY:   dummyReg <= wrData & DUMMY_KEEP;
          REG_BUF:     bufReg   <= wrData & BUF_KEEP;
          REG_START:   if (wrData[3] && !busy && !startPend) startPend <= 1'b1;
          REG_STATUS:  doneBit  <= doneBit & ~wrData[3];
          REG_MASK:    maskReg  <= wrData;
          REG_CONTROL: unitBit  <= wrData[3];
          default:     ;
        endcase
      end
      if (doneSet) doneBit <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      REG_CMD:     rdData = cmdWord;
      REG_LEN:     rdData = 32'(lenWords);
      REG_DUMMY:   rdData = dummyReg;
      REG_BUF:     rdData = bufReg;
      REG_START:   rdData = {28'h0, startPend, 3'b000};
      REG_STATUS:  rdData = {16'h0000, statusVec};
      REG_MASK:    rdData = maskReg;
      REG_CONTROL: rdData = {28'h0, unitBit, 3'b000};
      default:     rdData = '0;
    endcase
  end

  // R6: completion flag only drops through a write-one to it
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneBit && !(wrEn && addr == REG_STATUS && wrData[3])) |=> doneBit);

  // R7: no start can be pending while a read runs
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !startPend);

  // R8: interrupt only with a status bit set
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusVec != 16'h0000));

endmodule

// File: rtl/fdr_ctrl.sv
module fdr_ctrl
  import fdr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPend,
  input  logic             rxReset,
  input  logic [LEN_W-1:0] lenWords,
  input  logic [4:0]       dummyFast,
  output logic             accept,
  output logic             busy,
  output logic             doneSet,
  output logic             csN,
  output logic             sclk,
  output fdrStrobe_t       strobe
);

  localparam int CNT_W   = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
  localparam int DBITS_W = LEN_W + 5;
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(2 * HALF_DIV - 1);

  fdrState_t          state;
  logic [CNT_W-1:0]   phaseCnt;
  logic [DBITS_W-1:0] bitCnt;
  logic               midEdge;
  logic               endEdge;
  logic               lastBit;

  assign busy    = (state != ST_IDLE);
  assign midEdge = busy && (phaseCnt == MID_CNT);
  assign endEdge = busy && (phaseCnt == END_CNT);
  assign accept  = (state == ST_IDLE) && startPend && !rxReset;

  always_comb begin
    case (state)
      ST_CMD:   lastBit = (bitCnt == DBITS_W'(31));
      ST_DUMMY: lastBit = (bitCnt == DBITS_W'(dummyFast) - DBITS_W'(1));
      ST_DATA:  lastBit = (bitCnt == {lenWords, 5'h1f});
      default:  lastBit = 1'b0;
    endcase
  end

  assign strobe.loadCmd  = accept;
  assign strobe.shiftTx  = endEdge && (state == ST_CMD);
  assign strobe.sampleRx = midEdge && (state == ST_DATA) && !rxReset;
  assign strobe.clearRx  = accept || rxReset;
  assign doneSet         = endEdge && (state == ST_DATA) && lastBit && !rxReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else if (rxReset) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else if (state == ST_IDLE) begin
      if (accept) begin
        state    <= ST_CMD;
        csN      <= 1'b0;
        phaseCnt <= '0;
        bitCnt   <= '0;
      end
    end else begin
      phaseCnt <= endEdge ? '0 : phaseCnt + 1'b1;
      if (midEdge) sclk <= 1'b1;
      if (endEdge) begin
        sclk <= 1'b0;
        if (lastBit) begin
          bitCnt <= '0;
          case (state)
            ST_CMD:   state <= (dummyFast == 5'd0) ? ST_DATA : ST_DUMMY;
            ST_DUMMY: state <= ST_DATA;
            ST_DATA: begin
              state <= ST_IDLE;
              csN   <= 1'b1;
            end
            default:  state <= ST_IDLE;
          endcase
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R2: clock stays idle while the flash is deselected
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R6: completion coincides with releasing the flash
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneSet |=> (csN && !busy));

  // R9: a receive reset ends any frame at once
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxReset |=> (csN && !busy));

endmodule

// File: rtl/fdr_datapath.sv
module fdr_datapath
  import fdr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  fdrStrobe_t  strobe,
  input  logic [31:0] cmdWord,
  input  logic [19:0] bufBase,
  input  logic        miso,
  output logic        mosi,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData
);

  logic [31:0]      txShift;
  logic [6:0]       rxShift;
  logic [2:0]       bitIdx;
  logic [1:0]       byteIdx;
  logic [23:0]      wordBuf;
  logic [LEN_W-1:0] wordIdx;
  logic [7:0]       newByte;

  assign mosi    = txShift[31];
  assign newByte = {rxShift, miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobe.loadCmd) begin
      txShift <= {cmdWord[7:0], cmdWord[31:8]};
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      bitIdx    <= '0;
      byteIdx   <= '0;
      wordBuf   <= '0;
      wordIdx   <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else begin
      memWrEn <= 1'b0;
      if (strobe.clearRx) begin
        bitIdx  <= '0;
        byteIdx <= '0;
        wordIdx <= '0;
      end else if (strobe.sampleRx) begin
        rxShift <= newByte[6:0];
        bitIdx  <= bitIdx + 1'b1;
        if (bitIdx == 3'd7) begin
          byteIdx <= byteIdx + 1'b1;
          case (byteIdx)
            2'd0: wordBuf[7:0]   <= newByte;
            2'd1: wordBuf[15:8]  <= newByte;
            2'd2: wordBuf[23:16] <= newByte;
            default: begin
              memWrEn   <= 1'b1;
              memWrData <= {newByte, wordBuf};
              memWrAddr <= {bufBase, 12'h000} + 32'({wordIdx, 2'b00});
              wordIdx   <= wordIdx + 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R4: every word write follows a sampled data bit
  p_wr_after_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(strobe.sampleRx));

  // R4: word writes are single-cycle strobes
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R9: a reset of the receive logic suppresses the pending write
  p_clear_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearRx |=> !memWrEn);

endmodule

// File: rtl/flash_dma_reader.sv
module flash_dma_reader
  import fdr_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        spiCsN,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [31:0] memWrData,
  output logic        irq
);

  logic             busy;
  logic             accept;
  logic             doneSet;
  logic             startPend;
  logic             rxReset;
  logic [31:0]      cmdWord;
  logic [LEN_W-1:0] lenWords;
  logic [4:0]       dummyFast;
  logic [19:0]      bufBase;
  fdrStrobe_t       strobe;

  fdr_regs #(.LEN_W(LEN_W)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (regWrEn),
    .addr      (regAddr),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .busy      (busy),
    .accept    (accept),
    .doneSet   (doneSet),
    .startPend (startPend),
    .rxReset   (rxReset),
    .cmdWord   (cmdWord),
    .lenWords  (lenWords),
    .dummyFast (dummyFast),
    .bufBase   (bufBase),
    .irq       (irq)
  );

  fdr_ctrl #(.HALF_DIV(HALF_DIV), .LEN_W(LEN_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPend (startPend),
    .rxReset   (rxReset),
    .lenWords  (lenWords),
    .dummyFast (dummyFast),
    .accept    (accept),
    .busy      (busy),
    .doneSet   (doneSet),
    .csN       (spiCsN),
    .sclk      (spiSclk),
    .strobe    (strobe)
  );

  fdr_datapath #(.LEN_W(LEN_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdWord   (cmdWord),
    .bufBase   (bufBase),
    .miso      (spiMiso),
    .mosi      (spiMosi),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData)
  );

endmodule

// File: tb/tb_flash_dma_reader.sv
`timescale 1ns/1ps
module tb_flash_dma_reader;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        spiCsN, spiSclk, spiMosi;
  logic        spiMiso = 1'b0;
  logic        memWrEn;
  logic [31:0] memWrAddr, memWrData;
  logic        irq;

  int totalCnt = 0;
  int passCnt  = 0;

  int curSeed     = 0;
  int slaveDummy  = 0;
  int rises       = 0;
  int dummyHigh   = 0;
  int csFalls     = 0;
  int csLow       = 0;
  int wrCount     = 0;
  logic [31:0] cmdCap = 32'h0;
  logic [31:0] wrAddrLog [0:15];
  logic [31:0] wrDataLog [0:15];

  always #2.5 clk = ~clk;

  flash_dma_reader #(.HALF_DIV(HALF), .LEN_W(16)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .spiCsN(spiCsN),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .irq(irq)
  );

  function automatic logic [7:0] fbyte(int seed, int k);
    return 8'(seed + k * 29 + (k >> 2));
  endfunction

  function automatic logic [31:0] expWord(int seed, int i);
    return {fbyte(seed, 4*i+3), fbyte(seed, 4*i+2), fbyte(seed, 4*i+1), fbyte(seed, 4*i)};
  endfunction

  // flash model
  always @(negedge spiCsN) begin
    rises = 0;
    csFalls = csFalls + 1;
  end

  always @(posedge spiSclk) begin
    if (rises < 32) cmdCap = {cmdCap[30:0], spiMosi};
    else if (rises < 32 + slaveDummy && spiMosi) dummyHigh = dummyHigh + 1;
    rises = rises + 1;
  end

  always @(negedge spiSclk) begin : flashOut
    int idx;
    logic [7:0] b;
    idx = rises - 32 - slaveDummy;
    if (idx >= 0) begin
      b = fbyte(curSeed, idx / 8);
      spiMiso <= b[7 - (idx % 8)];
    end
  end

  always @(negedge clk) begin
    if (rstN && !spiCsN) csLow = csLow + 1;
    if (rstN && memWrEn) begin
      if (wrCount < 16) begin
        wrAddrLog[wrCount] = memWrAddr;
        wrDataLog[wrCount] = memWrData;
      end
      wrCount = wrCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitDone(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int n = 0; n < 20000; n++) begin
      regRead(3'd5, s);
      if (s[3]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic runRead(input int seed, input logic [7:0] op, input logic [23:0] fa,
                         input logic [31:0] dummyRegVal, input int dummy,
                         input int lenM1, input logic [19:0] base);
    bit ok;
    logic [31:0] r;
    int bits;
    curSeed = seed; slaveDummy = dummy; wrCount = 0; dummyHigh = 0; csLow = 0;
    bits = 32 + dummy + 32 * (lenM1 + 1);
    regWrite(3'd0, {fa, op});
    regWrite(3'd1, 32'(lenM1));
    regWrite(3'd2, dummyRegVal);
    regWrite(3'd3, {base, 12'h021});
    regWrite(3'd4, 32'h8);
    regRead(3'd4, r);
    check(r == 32'h0, "R7 start bit self-clears", r, 32'h0);
    waitDone(ok);
    check(ok, "R6 completion flag set", 32'(ok), 32'h1);
    check(spiCsN == 1'b1, "R6 chip select high at completion", 32'(spiCsN), 32'h1);
    check(cmdCap == {op, fa}, "R2 opcode and address", cmdCap, {op, fa});
    check(csLow == bits * 2 * HALF, "R2 frame length in clocks", 32'(csLow),
          32'(bits * 2 * HALF));
    check(dummyHigh == 0, "R3 mosi low in dummy clocks", 32'(dummyHigh), 32'h0);
    check(rises == bits, "R5 SPI bit count", 32'(rises), 32'(bits));
    check(wrCount == lenM1 + 1, "R5 word write count", 32'(wrCount), 32'(lenM1 + 1));
    for (int i = 0; i <= lenM1 && i < 16 && i < wrCount; i++) begin
      check(wrAddrLog[i] == {base, 12'h000} + 32'(4 * i), "R4 word address",
            wrAddrLog[i], {base, 12'h000} + 32'(4 * i));
      check(wrDataLog[i] == expWord(seed, i), "R4 word data little-endian",
            wrDataLog[i], expWord(seed, i));
    end
  endtask

  task automatic t_reset;
    logic [31:0] r;
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), r);
      check(r == 32'h0, "R1 register reset value", r, 32'h0);
    end
    check(spiCsN && !spiSclk && !irq && !memWrEn, "R1 output reset state",
          {28'h0, spiCsN, spiSclk, irq, memWrEn}, 32'h8);
  endtask

  task automatic t_regs;
    logic [31:0] r;
    regWrite(3'd0, 32'hFFFF_FFFF); regRead(3'd0, r);
    check(r == 32'hFFFF_FFFF, "R10 command register", r, 32'hFFFF_FFFF);
    regWrite(3'd1, 32'hFFFF_FFFF); regRead(3'd1, r);
    check(r == 32'h0000_FFFF, "R10 length register", r, 32'h0000_FFFF);
    regWrite(3'd2, 32'hFFFF_FFFF); regRead(3'd2, r);
    check(r == 32'h0F1F_1F1F, "R10 dummy register", r, 32'h0F1F_1F1F);
    regWrite(3'd3, 32'hFFFF_FFFF); regRead(3'd3, r);
    check(r == 32'hFFFF_F03F, "R10 buffer register", r, 32'hFFFF_F03F);
    regWrite(3'd6, 32'hFFFF_FFFF); regRead(3'd6, r);
    check(r == 32'hFFFF_FFFF, "R10 mask register", r, 32'hFFFF_FFFF);
    regWrite(3'd7, 32'hFFFF_FFFF); regRead(3'd7, r);
    check(r == 32'h0000_0008, "R10 R9 control readback", r, 32'h8);
    regWrite(3'd5, 32'hFFFF_FFFF); regRead(3'd5, r);
    check(r == 32'h0 && !irq, "R6 status write with nothing set", r, 32'h0);
    regWrite(3'd6, 32'h0);
    regWrite(3'd7, 32'h0);
  endtask

  task automatic t_status_irq;
    logic [31:0] r;
    check(!irq, "R8 irq low with mask clear", 32'(irq), 32'h0);
    regWrite(3'd5, 32'h0); regRead(3'd5, r);
    check(r == 32'h8, "R6 zero write keeps flag", r, 32'h8);
    regWrite(3'd6, 32'h0008_0000);
    #1;
    check(irq, "R8 irq with mask bit 19", 32'(irq), 32'h1);
    regWrite(3'd5, 32'h8); regRead(3'd5, r);
    check(r == 32'h0, "R6 write-one clears flag", r, 32'h0);
    check(!irq, "R8 irq drops after clear", 32'(irq), 32'h0);
    regWrite(3'd6, 32'h0);
  endtask

  task automatic t_busy_start;
    bit ok;
    logic [31:0] r;
    int falls0;
    curSeed = 7; slaveDummy = 0; wrCount = 0;
    regWrite(3'd1, 32'd1);
    regWrite(3'd2, 32'h0);
    falls0 = csFalls;
    regWrite(3'd4, 32'h8);
    repeat (60) @(negedge clk);
    regWrite(3'd4, 32'h8);
    regRead(3'd4, r);
    check(r == 32'h0, "R7 start during read not pending", r, 32'h0);
    waitDone(ok);
    repeat (200) @(negedge clk);
    check(csFalls - falls0 == 1, "R7 start during read ignored", 32'(csFalls - falls0), 32'h1);
    check(wrCount == 2, "R7 only one read's words", 32'(wrCount), 32'h2);
    regWrite(3'd5, 32'h8);
  endtask

  task automatic t_rx_reset;
    logic [31:0] r;
    int n;
    curSeed = 11; slaveDummy = 2; wrCount = 0;
    regWrite(3'd1, 32'd3);
    regWrite(3'd2, 32'd2);
    regWrite(3'd3, 32'h0007_0000);
    regWrite(3'd4, 32'h8);
    n = 0;
    while (wrCount < 1 && n < 5000) begin @(negedge clk); n++; end
    regWrite(3'd7, 32'h20);
    repeat (2) @(negedge clk);
    check(spiCsN, "R9 chip select released", 32'(spiCsN), 32'h1);
    repeat (300) @(negedge clk);
    check(wrCount == 1, "R9 no writes after reset", 32'(wrCount), 32'h1);
    regRead(3'd5, r);
    check(r == 32'h0, "R9 no completion after abort", r, 32'h0);
    regRead(3'd7, r);
    check(r == 32'h0, "R9 control bit reads zero", r, 32'h0);
    runRead(23, 8'h03, 24'h00AB00, 32'h0, 0, 0, 20'h00090);
    regWrite(3'd5, 32'h8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    totalCnt++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    // page address 0x1234 widened by an 8-bit shift, no dummy, one word
    runRead(5, 8'h03, 24'h123400, 32'h0, 0, 0, 20'h00045);
    t_status_irq();
    // fast read, eight dummy clocks, dual/quad/preamble fields set
    runRead(91, 8'h0B, 24'hABCDEF, 32'h0F1F_1408, 8, 3, 20'hC0DE1);
    regWrite(3'd5, 32'h8);
    runRead(200, 8'h0B, 24'h00F0F0, 32'h0000_001F, 31, 1, 20'h00100);
    regWrite(3'd5, 32'h8);
    t_busy_start();
    t_rx_reset();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule